// File: doc/BRIEF.md
# Counted Block Memory Copy Engine

This block moves a run of bytes from a source pointer to a destination pointer through a single synchronous byte memory port. A start pulse loads both 24-bit pointers, a byte count and a mode bit. The block then walks the run one byte at a time. Each step is a read at the source, a one-cycle wait for the memory's read data, a write at the destination, and a pointer and count update. It pulses done at the end. The final pointers and the remaining count stay visible on its outputs, ready for the caller to write back.

There are two modes. Narrow mode takes its count from the low 8 bits of the count input. It holds off both maskable and non-maskable interrupt requests until the run completes. Wide mode takes the full 16-bit count and holds off only maskable requests. In wide mode a non-maskable request ends the run at the next byte boundary. The pointers and the count are left where they stopped, the block raises an abort flag, and it does not pick the run up again by itself. Every run is busy for a fixed eight cycles of overhead plus four cycles per byte moved.

Top module: `blkcopy_engine`

## Requirements
- R1: Byte k of a run (k counted from 0) is read at source+k and written unchanged at destination+k. Bytes go in increasing order, and each write comes two cycles after its read.
- R2: With wide_i = 0 at start, the count is cnt_i[7:0] and cnt_i[15:8] has no effect. cnt_o[15:8] reads 0 for the whole run.
- R3: With wide_i = 1 at start, the count is the full cnt_i[15:0].
- R4: busy_o is high for exactly 8 + 4·n cycles after the start edge, where n is the number of bytes moved. done_o is high for exactly one cycle, the first cycle in which busy_o is low again.
- R5: A starting count of zero makes no memory write. The run still lasts the 8-cycle overhead.
- R6: A run that is not cut short ends with cnt_o = 0, src_o = source + n, dst_o = destination + n, and aborted_o = 0.
- R7: Both pointers are 24 bits wide and wrap from 0xFFFFFF to 0x000000.
- R8: While busy_o is high, irq_o stays low in both modes. While idle, irq_o follows irq_i.
- R9: In narrow mode a non-maskable request has no effect on the run: every byte is copied and nmi_o stays low while busy. While idle, nmi_o follows nmi_i.
- R10: In wide mode a non-maskable request stops the run at a byte boundary and passes through on nmi_o. With k bytes written, the run ends with cnt_o = n − k ≠ 0, pointers advanced by k, aborted_o = 1 and a busy time of 8 + 4·k cycles. The run does not resume.
- R11: A start pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| wide_i | input | 1 | Mode at start: 0 = 8-bit count, 1 = 16-bit count |
| src_i | input | 24 | Source pointer loaded at start |
| dst_i | input | 24 | Destination pointer loaded at start |
| cnt_i | input | 16 | Byte count loaded at start |
| irq_i | input | 1 | Maskable interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| mem_addr_o | output | 24 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| aborted_o | output | 1 | Last run ended with a nonzero count |
| src_o | output | 24 | Current or final source pointer |
| dst_o | output | 24 | Current or final destination pointer |
| cnt_o | output | 16 | Current or remaining count |
| irq_o | output | 1 | Maskable request after masking |
| nmi_o | output | 1 | Non-maskable request after masking |

## Verification
The copy is run in both modes with several counts: small runs, a run longer than 256 bytes that needs the wide count, a narrow run whose cnt_i upper byte is nonzero, and a zero count. Each count is checked against the bytes written, the busy time and the final pointers, so a miscounted step, a wrong overhead or a stray write shows up separately. Two runs place the source and then the destination just below the top of the address space, which separates correct 24-bit wrap from truncation. The interrupt cases hold the non-maskable request high in narrow mode and raise it part way through a wide run, which separates masking from abort. A start pulse in the middle of a run confirms that the first run's results are kept.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_STEP,
    ST_POST
  } cp_state_e;
endpackage

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
#(
  parameter int PRE_CYC  = 4,
  parameter int POST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wide_q_i,
  input  logic nmi_i,
  input  logic cnt_zero_i,
  input  logic cnt_one_i,
  output logic load_o,
  output logic rd_o,
  output logic cap_o,
  output logic wr_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);
  localparam int PH_MAX = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  cp_state_e       state_q, state_d;
  logic [PH_W-1:0] ph_q;
  logic            done_q;
  logic            abort_req;
  logic            pre_last, post_last;

  assign abort_req = wide_q_i & nmi_i;
  assign pre_last  = (state_q == ST_PRE)  && (ph_q == PH_W'(PRE_CYC - 1));
  assign post_last = (state_q == ST_POST) && (ph_q == PH_W'(POST_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PRE;
      ST_PRE:  if (pre_last) state_d = (cnt_zero_i || abort_req) ? ST_POST : ST_RD;
      ST_RD:   state_d = ST_WAIT;
      ST_WAIT: state_d = ST_WR;
      ST_WR:   state_d = ST_STEP;
      ST_STEP: state_d = (cnt_one_i || abort_req) ? ST_POST : ST_RD;
      ST_POST: if (post_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= post_last;
      if (state_d != state_q || !(state_q == ST_PRE || state_q == ST_POST)) ph_q <= '0;
      else ph_q <= ph_q + PH_W'(1);
    end
  end

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign rd_o     = (state_q == ST_RD);
  assign cap_o    = (state_q == ST_WAIT);
  assign wr_o     = (state_q == ST_WR);
  assign step_o   = (state_q == ST_STEP);
  assign finish_o = post_last;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R1
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(rd_o, 2));
endmodule

// File: rtl/blkcopy_regs.sv
module blkcopy_regs #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int BCNT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cap_i,
  input  logic              step_i,
  input  logic              wr_i,
  input  logic              finish_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wide_o,
  output logic              cnt_zero_o,
  output logic              cnt_one_o,
  output logic              aborted_o
);
  localparam int HI_W = CNT_W - BCNT_W;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, cnt_load;
  logic [DATA_W-1:0] data_q;
  logic              wide_q, aborted_q;

  // narrow mode drops the upper count byte at load
  assign cnt_load = wide_i ? cnt_i : {{HI_W{1'b0}}, cnt_i[BCNT_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      data_q    <= '0;
      wide_q    <= 1'b0;
      aborted_q <= 1'b0;
    end else begin
      if (load_i) begin
        src_q     <= src_i;
        dst_q     <= dst_i;
        cnt_q     <= cnt_load;
        wide_q    <= wide_i;
        aborted_q <= 1'b0;
      end else if (step_i) begin
        src_q <= src_q + ADDR_W'(1);
        dst_q <= dst_q + ADDR_W'(1);
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (cap_i) data_q <= rdata_i;
      if (finish_i) aborted_q <= (cnt_q != '0);
    end
  end

  assign mem_addr_o  = wr_i ? dst_q : src_q;
  assign mem_wdata_o = data_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;
  assign wide_o      = wide_q;
  assign cnt_zero_o  = (cnt_q == '0);
  assign cnt_one_o   = (cnt_q == CNT_W'(1));
  assign aborted_o   = aborted_q;

  // R10
  step_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !cnt_zero_o);

  // R9
  narrow_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_i && !wide_q) |-> cnt_zero_o);

  // R2
  narrow_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_q |-> (cnt_q[CNT_W-1:BCNT_W] == '0));
endmodule

// File: rtl/blkcopy_irq_gate.sv
module blkcopy_irq_gate (
  input  logic busy_i,
  input  logic wide_i,
  input  logic irq_i,
  input  logic nmi_i,
  output logic irq_o,
  output logic nmi_o
);
  // maskable held off in both modes, non-maskable only in narrow mode
  assign irq_o = irq_i & ~busy_i;
  assign nmi_o = nmi_i & ~(busy_i & ~wide_i);
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int ADDR_W   = 24,
  parameter int CNT_W    = 16,
  parameter int BCNT_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PRE_CYC  = 4,
  parameter int POST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  input  logic              nmi_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              aborted_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o,
  output logic              nmi_o
);
  logic load, rd, cap, wr, step, finish;
  logic wide_q, cnt_zero, cnt_one;

  blkcopy_ctrl #(
    .PRE_CYC (PRE_CYC),
    .POST_CYC(POST_CYC)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .wide_q_i  (wide_q),
    .nmi_i     (nmi_i),
    .cnt_zero_i(cnt_zero),
    .cnt_one_i (cnt_one),
    .load_o    (load),
    .rd_o      (rd),
    .cap_o     (cap),
    .wr_o      (wr),
    .step_o    (step),
    .finish_o  (finish),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  blkcopy_regs #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .BCNT_W(BCNT_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .wide_i     (wide_i),
    .src_i      (src_i),
    .dst_i      (dst_i),
    .cnt_i      (cnt_i),
    .cap_i      (cap),
    .step_i     (step),
    .wr_i       (wr),
    .finish_i   (finish),
    .rdata_i    (mem_rdata_i),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .src_o      (src_o),
    .dst_o      (dst_o),
    .cnt_o      (cnt_o),
    .wide_o     (wide_q),
    .cnt_zero_o (cnt_zero),
    .cnt_one_o  (cnt_one),
    .aborted_o  (aborted_o)
  );

  blkcopy_irq_gate u_gate (
    .busy_i(busy_o),
    .wide_i(wide_q),
    .irq_i (irq_i),
    .nmi_i (nmi_i),
    .irq_o (irq_o),
    .nmi_o (nmi_o)
  );

  assign mem_we_o = wr;

  // R5
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: tb/blkcopy_engine_tb.sv
module blkcopy_engine_tb;
  typedef struct packed {
    logic        wide;
    logic [23:0] src;
    logic [23:0] dst;
    logic [15:0] cnt;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t [0:NV-1] VECS = '{
    '{1'b0, 24'h000010, 24'h000100, 16'h0005, 16'd5},    // R1 narrow
    '{1'b0, 24'h000020, 24'h000200, 16'hAB03, 16'd3},    // R2 upper byte ignored
    '{1'b1, 24'h000040, 24'h000300, 16'h0106, 16'd262},  // R3 wide
    '{1'b1, 24'h000010, 24'h000100, 16'h0000, 16'd0},    // R5 zero
    '{1'b0, 24'hFFFFFE, 24'h000200, 16'h0004, 16'd4},    // R7 source wrap
    '{1'b1, 24'h000080, 24'hFFFFFD, 16'h0005, 16'd5}     // R7 destination wrap
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [23:0] src_i = '0;
  logic [23:0] dst_i = '0;
  logic [15:0] cnt_i = '0;
  logic        irq_i = 1'b0;
  logic        nmi_i = 1'b0;
  logic [23:0] mem_addr_o;
  logic        mem_we_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        busy_o, done_o, aborted_o, irq_o, nmi_o;
  logic [23:0] src_o, dst_o;
  logic [15:0] cnt_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  blkcopy_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wide_i(wide_i),
    .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i), .irq_i(irq_i), .nmi_i(nmi_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .aborted_o(aborted_o), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o),
    .irq_o(irq_o), .nmi_o(nmi_o)
  );

  // memory model: 1 KiB aliased, one-cycle read latency
  logic [7:0] mem [0:1023];
  logic       fill_req = 1'b0;
  logic       mon_clr = 1'b0;
  int         wr_cnt = 0;
  int         busy_cyc = 0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always @(posedge clk_i) begin
    mem_rdata_i <= mem[mem_addr_o[9:0]];
    if (fill_req) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (mem_we_o) begin
      mem[mem_addr_o[9:0]] <= mem_wdata_o;
    end
    if (mon_clr) begin
      wr_cnt   <= 0;
      busy_cyc <= 0;
    end else begin
      if (mem_we_o) wr_cnt <= wr_cnt + 1;
      if (busy_o) busy_cyc <= busy_cyc + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk_i);
    fill_req = 1'b1;
    mon_clr  = 1'b1;
    @(negedge clk_i);
    fill_req = 1'b0;
    mon_clr  = 1'b0;
  endtask

  task automatic start_op(logic w, logic [23:0] s, logic [23:0] d, logic [15:0] c);
    wide_i  = w;
    src_i   = s;
    dst_i   = d;
    cnt_i   = c;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done_o) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int mism;
    logic [23:0] a;
    logic [15:0] cnt_hold;

    repeat (3) @(negedge clk_i);
    // reset state
    chk("R4 reset busy", 32'(busy_o), 0);
    chk("R4 reset done", 32'(done_o), 0);
    chk("R5 reset we", 32'(mem_we_o), 0);
    chk("R6 reset aborted", 32'(aborted_o), 0);
    chk("R6 reset cnt", 32'(cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk
    for (int v = 0; v < NV; v++) begin
      prep();
      start_op(VECS[v].wide, VECS[v].src, VECS[v].dst, VECS[v].cnt);
      if (!VECS[v].wide) chk("R2 cnt_o high byte", 32'(cnt_o[15:8]), 0);
      wait_done(ok);
      chk("R4 done seen", 32'(ok), 1);
      chk("R4 busy cycles", 32'(busy_cyc), 32'(8 + 4 * int'(VECS[v].n)));
      chk("R4 busy low at done", 32'(busy_o), 0);
      chk("R5 write count", 32'(wr_cnt), 32'(VECS[v].n));
      chk("R6 cnt", 32'(cnt_o), 0);
      chk("R6 aborted", 32'(aborted_o), 0);
      chk("R7 src", 32'(src_o), 32'(24'(VECS[v].src + 24'(VECS[v].n))));
      chk("R7 dst", 32'(dst_o), 32'(24'(VECS[v].dst + 24'(VECS[v].n))));
      mism = 0;
      for (int k = 0; k < int'(VECS[v].n); k++) begin
        a = VECS[v].src + 24'(k);
        if (mem[10'(VECS[v].dst + 24'(k))] !== pat(int'(a[9:0]))) mism++;
      end
      chk("R1 copied bytes", 32'(mism), 0);
      a = VECS[v].dst + 24'(VECS[v].n);
      chk("R1 byte past end", 32'(mem[a[9:0]]), 32'(pat(int'(a[9:0]))));
      @(negedge clk_i);
      chk("R4 done one cycle", 32'(done_o), 0);
    end

    // R11: start while busy ignored
    prep();
    start_op(1'b0, 24'h000010, 24'h000100, 16'h0006);
    repeat (5) @(negedge clk_i);
    start_op(1'b1, 24'h000050, 24'h000180, 16'h0200);
    wait_done(ok);
    chk("R11 busy cycles", 32'(busy_cyc), 32);
    chk("R11 writes", 32'(wr_cnt), 6);
    chk("R11 src", 32'(src_o), 32'h16);
    chk("R11 dst", 32'(dst_o), 32'h106);

    // R8/R9: narrow mode holds both requests off
    prep();
    irq_i = 1'b1;
    nmi_i = 1'b1;
    start_op(1'b0, 24'h000040, 24'h000200, 16'h0008);
    repeat (6) @(negedge clk_i);
    chk("R8 irq masked busy", 32'(irq_o), 0);
    chk("R9 nmi masked narrow", 32'(nmi_o), 0);
    wait_done(ok);
    chk("R9 all bytes", 32'(wr_cnt), 8);
    chk("R9 cnt", 32'(cnt_o), 0);
    chk("R9 aborted", 32'(aborted_o), 0);
    chk("R8 irq idle", 32'(irq_o), 1);
    chk("R9 nmi idle", 32'(nmi_o), 1);
    irq_i = 1'b0;
    nmi_i = 1'b0;

    // R10: wide mode abort
    prep();
    irq_i = 1'b1;
    start_op(1'b1, 24'h000040, 24'h000300, 16'd50);
    for (int i = 0; i < 100 && wr_cnt < 3; i++) @(negedge clk_i);
    chk("R8 irq masked wide", 32'(irq_o), 0);
    nmi_i = 1'b1;
    #1;
    chk("R10 nmi passes wide", 32'(nmi_o), 1);
    wait_done(ok);
    nmi_i = 1'b0;
    irq_i = 1'b0;
    chk("R10 done", 32'(ok), 1);
    chk("R10 stopped early", 32'(wr_cnt >= 3 && wr_cnt < 50), 1);
    chk("R10 cnt left", 32'(cnt_o), 32'(50 - wr_cnt));
    chk("R10 aborted", 32'(aborted_o), 1);
    chk("R10 busy cycles", 32'(busy_cyc), 32'(8 + 4 * wr_cnt));
    chk("R10 src", 32'(src_o), 32'(24'h40 + 24'(wr_cnt)));
    chk("R10 dst", 32'(dst_o), 32'(24'h300 + 24'(wr_cnt)));
    cnt_hold = cnt_o;
    repeat (20) @(negedge clk_i);
    chk("R10 no resume busy", 32'(busy_o), 0);
    chk("R10 no resume cnt", 32'(cnt_o), 32'(cnt_hold));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule